// File: doc/BRIEF.md
# Periodic and Alarm Interrupt Controller

This block drives a single active-low interrupt line. Two sources share it: a periodic interrupt whose rate is picked from a divider chain, and an alarm interrupt raised when an external comparator reports that clock time equals alarm time. The divider taps, the seconds and minutes strobes, the 32.768 kHz tick and the match signal all come from outside. The block only turns them into requests, holds the status flags and merges the requests onto the line. Nothing here depends on a chip-enable input, so the line keeps working while the host bus is shut off.

A 4-bit mode word sets the behaviour. The low three bits pick the source: off, one of four fast taps, the seconds rate, the minutes rate, or a constant assertion. The top bit picks how the request behaves. In pulse style the request is a square wave at half duty and cannot be cleared. In latch style each period sets the request, and it stays set until software clears it. Software sees the periodic and alarm requests as two flags. Writing 0 to a flag clears it. Writing 1 does nothing.

Top module: `cyc_alarm_irq`

## Requirements
- R1: While reset is held and right after it, `irq_n` is 1 and both flags are 0. The mode word resets to 0000 and the alarm enable resets to 0.
- R2: With select bits 000, no periodic request is raised, whatever the taps or strobes do.
- R3: With select 001/010/011/100 (taps bit 0, 1, 2, 3) in pulse style (mode bit 3 = 0), the periodic flag follows the level of the selected tap one clock later. Taps that are not selected have no effect.
- R4: With select 101 in pulse style, the request rises at the first tick after a seconds strobe. It falls exactly HALF_TICKS ticks later.
- R5: With select 110 in pulse style, the request rises at the first tick after a minutes strobe. It falls on the HALF_MIN_SECS-th later seconds event.
- R6: In latch style (mode bit 3 = 1), a period start sets the periodic flag. The flag stays set until a flag write with bit 0 = 0, which clears it one clock later.
- R7: In pulse style, a flag write with bit 0 = 0 does not change the periodic flag.
- R8: With select 111, the periodic flag is 1 and `irq_n` is 0 from the clock after the mode write, and a flag write does not clear it.
- R9: When the alarm is enabled, a rising edge of the match signal sets the alarm flag one clock later. While the alarm is disabled, the alarm flag is 0.
- R10: Writing the alarm enable to 0 clears the alarm flag and releases its request one clock later.
- R11: Writing the alarm enable to 1 while the match signal is already high sets the alarm flag within two clocks.
- R12: A flag write with bit 1 = 0 clears the alarm flag, and the flag stays clear while the match stays high. A flag write with bit 1 = 1 leaves the alarm flag as it is.
- R13: `irq_n` is 0 exactly when either flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock strobe per 32.768 kHz period |
| taps | input | 4 | Square-wave taps: 2048, 1024, 128, 16 Hz |
| sec_step | input | 1 | Strobe when the seconds count advances |
| min_step | input | 1 | Strobe when the minutes count advances |
| alarm_hit | input | 1 | High while clock time matches alarm time |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 4 | Mode word: bit 3 style, bits 2:0 select |
| alen_we | input | 1 | Alarm enable write strobe |
| alen_wdata | input | 1 | Alarm enable value |
| flag_we | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Bit 0 periodic, bit 1 alarm; 0 clears |
| irq_n | output | 1 | Active-low merged interrupt |
| cyc_flag | output | 1 | Periodic request active |
| alm_flag | output | 1 | Alarm request active |

## Verification
The assertions assume three things about the inputs. Taps change at most once per clock. A seconds or minutes strobe is a single clock wide and arrives when no tick is present. A minutes strobe always comes together with a seconds strobe. The stimulus toggles the tick on every other clock. It raises the strobes only on a clock where the tick is low and drops them after one clock. Each tap moves by a single level change before the design is sampled.

// File: rtl/cyc_alarm_irq.sv
module cyc_alarm_irq #(
  parameter int HALF_TICKS    = 16384,
  parameter int HALF_MIN_SECS = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] taps,
  input  logic       sec_step,
  input  logic       min_step,
  input  logic       alarm_hit,
  input  logic       mode_we,
  input  logic [3:0] mode_wdata,
  input  logic       alen_we,
  input  logic       alen_wdata,
  input  logic       flag_we,
  input  logic [1:0] flag_wdata,
  output logic       irq_n,
  output logic       cyc_flag,
  output logic       alm_flag
);
  localparam int LIM = (HALF_TICKS > HALF_MIN_SECS) ? HALF_TICKS : HALF_MIN_SECS;
  localparam int CW  = $clog2(LIM + 1);

  logic [3:0]    mode_q, tap_q;
  logic          sec_pend, min_pend, cyc_req, alm_req, alen_q, ah_q;
  logic [CW-1:0] span;
  logic          tap_now, tap_old, start, stop;

  wire       sec_evt = sec_pend & tick;
  wire       min_evt = min_pend & tick;
  wire [2:0] sel     = mode_q[2:0];
  wire       level   = mode_q[3];
  wire       unit    = (sel == 3'd5) ? tick : sec_evt;
  wire       cyc_clr = flag_we & ~flag_wdata[0] & level;
  wire       alm_clr = flag_we & ~flag_wdata[1];
  wire       alm_set = alen_q & alarm_hit & ~ah_q;

  always_comb begin
    tap_now = 1'b0;
    tap_old = 1'b0;
    if (sel >= 3'd1 && sel <= 3'd4) begin
      tap_now = taps[sel - 3'd1];
      tap_old = tap_q[sel - 3'd1];
    end
  end

  always_comb begin
    start = 1'b0;
    stop  = 1'b0;
    case (sel)
      3'd1, 3'd2, 3'd3, 3'd4: begin
        start = tap_now & ~tap_old;
        stop  = ~tap_now & tap_old;
      end
      3'd5: begin
        start = sec_evt;
        stop  = tick && span == CW'(1);
      end
      3'd6: begin
        start = min_evt;
        stop  = sec_evt && span == CW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      tap_q    <= '0;
      sec_pend <= 1'b0;
      min_pend <= 1'b0;
      cyc_req  <= 1'b0;
      span     <= '0;
    end else begin
      tap_q    <= taps;
      sec_pend <= sec_step | (sec_pend & ~tick);
      min_pend <= min_step | (min_pend & ~tick);
      if (mode_we) begin
        mode_q  <= mode_wdata;
        cyc_req <= (mode_wdata[2:0] == 3'd7);
        span    <= '0;
      end else begin
        if (sel == 3'd7)          cyc_req <= 1'b1;
        else if (start)           cyc_req <= 1'b1;
        else if (!level && stop)  cyc_req <= 1'b0;
        else if (cyc_clr)         cyc_req <= 1'b0;
        if (start)
          span <= (sel == 3'd5) ? CW'(HALF_TICKS) : CW'(HALF_MIN_SECS);
        else if (unit && span != '0)
          span <= span - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alen_q  <= 1'b0;
      ah_q    <= 1'b0;
      alm_req <= 1'b0;
    end else begin
      if (alen_we) alen_q <= alen_wdata;
      ah_q <= alen_q & alarm_hit;
      if (alen_we && !alen_wdata) alm_req <= 1'b0;
      else if (alm_set)           alm_req <= 1'b1;
      else if (alm_clr)           alm_req <= 1'b0;
    end
  end

  assign irq_n    = ~(cyc_req | alm_req);
  assign cyc_flag = cyc_req;
  assign alm_flag = alm_req;
endmodule

// File: rtl/cyc_alarm_irq_chk.sv
module cyc_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_q,
  input logic       alen_q,
  input logic       mode_we,
  input logic       alen_we,
  input logic       alen_wdata,
  input logic       flag_we,
  input logic [1:0] flag_wdata,
  input logic       irq_n,
  input logic       cyc_flag,
  input logic       alm_flag
);
  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] == 3'd0 && !mode_we) |=> !cyc_flag);

  a_r6_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && cyc_flag && !mode_we && !(flag_we && !flag_wdata[0])) |=> cyc_flag);

  a_r8_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2:0] == 3'd7) |-> !irq_n);

  a_r9_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !alen_q |-> !alm_flag);

  a_r10_alen_release: assert property (@(posedge clk) disable iff (!rst_n)
    (alen_we && !alen_wdata) |=> !alm_flag);

  a_r12_alm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_flag && !alen_we && !(flag_we && !flag_wdata[1])) |=> alm_flag);
endmodule

bind cyc_alarm_irq cyc_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .alen_q(alen_q),
  .mode_we(mode_we), .alen_we(alen_we), .alen_wdata(alen_wdata),
  .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_n(irq_n),
  .cyc_flag(cyc_flag), .alm_flag(alm_flag)
);

// File: tb/tb_cyc_alarm_irq.sv
module tb_cyc_alarm_irq;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, phase = 1'b0;
  logic [3:0] taps = '0, mode_wdata = '0;
  logic sec_step = 0, min_step = 0, alarm_hit = 0;
  logic mode_we = 0, alen_we = 0, alen_wdata = 0, flag_we = 0;
  logic [1:0] flag_wdata = '0;
  logic irq_n, cyc_flag, alm_flag;

  typedef struct { logic irq_n; logic cyc; logic alm; string req; } exp_t;
  exp_t sb[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cyc_alarm_irq #(.HALF_TICKS(4), .HALF_MIN_SECS(3)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .taps(taps), .sec_step(sec_step),
    .min_step(min_step), .alarm_hit(alarm_hit), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .alen_we(alen_we), .alen_wdata(alen_wdata),
    .flag_we(flag_we), .flag_wdata(flag_wdata), .irq_n(irq_n),
    .cyc_flag(cyc_flag), .alm_flag(alm_flag));

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      compared++;
      if (irq_n !== e.irq_n || cyc_flag !== e.cyc || alm_flag !== e.alm) begin
        mismatched++;
        $display("FAIL %s: got irq_n=%b cyc=%b alm=%b, expected irq_n=%b cyc=%b alm=%b",
                 e.req, irq_n, cyc_flag, alm_flag, e.irq_n, e.cyc, e.alm);
      end
    end
  end

  task automatic push(input logic i, input logic c, input logic a, input string r);
    exp_t e;
    e.irq_n = i; e.cyc = c; e.alm = a; e.req = r;
    sb.push_back(e);
  endtask

  task automatic step();
    @(posedge clk); #1;
    phase = ~phase;
    tick  = phase;
  endtask

  task automatic wr_mode(input logic [3:0] m);
    mode_we = 1; mode_wdata = m; step(); mode_we = 0;
  endtask

  task automatic wr_alen(input logic v);
    alen_we = 1; alen_wdata = v; step(); alen_we = 0;
  endtask

  task automatic wr_flag(input logic [1:0] v);
    flag_we = 1; flag_wdata = v; step(); flag_we = 0;
  endtask

  task automatic sec_pulse(input logic with_min);
    while (tick) step();
    sec_step = 1; min_step = with_min; step();
    sec_step = 0; min_step = 0; step();
  endtask

  initial begin
    step(); step();
    push(1, 0, 0, "R1");
    step();
    rst_n = 1;
    step();
    push(1, 0, 0, "R1");

    // R2: select 000 stays quiet
    wr_mode(4'b0000);
    taps = 4'hF; step(); taps = 4'h0; step();
    sec_pulse(1);
    push(1, 0, 0, "R2");

    // R3: pulse style follows selected tap
    wr_mode(4'b0011);
    taps[2] = 1; step();
    push(0, 1, 0, "R3");
    wr_flag(2'b00);
    push(0, 1, 0, "R7");
    taps[2] = 0; step();
    push(1, 0, 0, "R3");
    wr_mode(4'b0100);
    taps[0] = 1; step(); taps[0] = 0; step();
    push(1, 0, 0, "R3");
    taps[3] = 1; step();
    push(0, 1, 0, "R3");
    taps[3] = 0; step();
    push(1, 0, 0, "R3");

    // R6: latch style holds until cleared
    wr_mode(4'b1010);
    taps[1] = 1; step();
    push(0, 1, 0, "R6");
    taps[1] = 0; step(); step();
    push(0, 1, 0, "R6");
    wr_flag(2'b11);
    push(0, 1, 0, "R6");
    wr_flag(2'b10);
    push(1, 0, 0, "R6");

    // R4: seconds rate, edge one tick after strobe
    wr_mode(4'b0101);
    while (tick) step();
    sec_step = 1; step(); sec_step = 0;
    push(1, 0, 0, "R4");
    step();
    push(0, 1, 0, "R4");
    for (int k = 0; k < 7; k++) begin
      step();
      push(0, 1, 0, "R4");
    end
    step();
    push(1, 0, 0, "R4");

    // R5: minutes rate
    wr_mode(4'b0110);
    sec_pulse(1);
    push(0, 1, 0, "R5");
    sec_pulse(0); sec_pulse(0);
    push(0, 1, 0, "R5");
    sec_pulse(0);
    push(1, 0, 0, "R5");

    // R8 / R13: fixed low plus alarm
    wr_mode(4'b0111);
    push(0, 1, 0, "R8");
    wr_flag(2'b00);
    push(0, 1, 0, "R8");
    wr_alen(1);
    alarm_hit = 1; step();
    push(0, 1, 1, "R13");
    wr_alen(0);
    push(0, 1, 0, "R10");
    alarm_hit = 0;
    wr_mode(4'b0000);
    push(1, 0, 0, "R13");

    // R9 / R12 / R11 / R10
    wr_alen(1);
    push(1, 0, 0, "R9");
    alarm_hit = 1; step();
    push(0, 0, 1, "R9");
    wr_flag(2'b11);
    push(0, 0, 1, "R12");
    wr_flag(2'b01);
    push(1, 0, 0, "R12");
    step(); step();
    push(1, 0, 0, "R12");
    wr_alen(0);
    step();
    wr_alen(1);
    push(1, 0, 0, "R11");
    step();
    push(0, 0, 1, "R11");
    wr_alen(0);
    push(1, 0, 0, "R10");
    alarm_hit = 0;
    step(); step();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule